// File: doc/BRIEF.md
# 100 Mbps Transmit Symbol Encoder

This block sits between a MAC's nibble-wide transmit port and the serializer of a 100 Mbps link. On each 25 MHz clock it takes one transmit nibble together with its enable and error strobes, and it produces one 5-bit code group. It puts a start delimiter (/J/ then /K/) in place of the first two preamble nibbles of every frame. It maps each payload nibble through the 4B/5B table, or substitutes the /H/ error symbol. It closes the frame with an end delimiter (/T/ then /R/) and sends idle symbols between frames. It also produces carrier sense and collision flags from its own transmit activity and a receive-activity input, according to the configured duplex.

Two side modes are available. In symbol-bypass mode the MAC does its own coding: the error strobe becomes a fifth data bit and the code group passes through raw. In fiber mode a flag tells the downstream path not to scramble. Every output is registered, so each one reflects the inputs sampled on the previous rising clock edge.

The framing sequencer has four states. **IDLE** emits /I/, or emits /J/ and takes the *start* transition to SEND_K when the enable is high. **SEND_K** always emits /K/ and takes the *open* transition to DATA. **DATA** emits a coded nibble or /H/ while the enable is high, and on a low enable emits /T/ and takes the *close* transition to SEND_R. **SEND_R** always emits /R/ and takes the *rest* transition to IDLE. While bypass is high, every state takes the *bypass* transition to IDLE.

Top module: `txpcs_encoder`

## Requirements
- R1: While reset is low, and on the first clock after it is released with tx_en low, code_grp is idle 11111 and crs, col and scram_skip are 0.
- R2: Outside a frame with tx_en low, code_grp is idle 11111 one clock after sampling, whatever the values of tx_er and txd.
- R3: The clock that samples tx_en high in IDLE yields /J/ 11000. The next clock always yields /K/ 10001, whatever tx_en and tx_er are. Both preamble nibbles are consumed.
- R4: In DATA with tx_en high and tx_er low, the nibble 0..F maps to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: In DATA with tx_en and tx_er both high, code_grp is /H/ 00100 instead of the coded nibble.
- R6: The first clock in DATA with tx_en low yields /T/ 01101. The next clock yields /R/ 00111 whatever tx_en is. Idle 11111 follows unless a new frame starts.
- R7: With pcs_bypass high, code_grp one clock later is {tx_er, txd[3:0]} with no coding. The sequencer returns to IDLE, so the first normal clock afterwards sees IDLE.
- R8: crs is rx_active OR (half_duplex AND tx_en), sampled one clock earlier. In full duplex, transmit alone never raises it.
- R9: col is half_duplex AND tx_en AND rx_active, sampled one clock earlier. It stays 0 in full duplex.
- R10: scram_skip follows fiber_mode with one clock of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Nibble valid from the MAC |
| tx_er | input | 1 | Error strobe; fifth data bit in bypass |
| txd | input | 4 | Transmit nibble |
| rx_active | input | 1 | Receive carrier present |
| half_duplex | input | 1 | 1 = half duplex, 0 = full duplex |
| pcs_bypass | input | 1 | 1 = pass raw 5-bit groups |
| fiber_mode | input | 1 | 1 = fiber link selected |
| code_grp | output | 5 | Code group to the serializer |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |
| scram_skip | output | 1 | Tell downstream to skip scrambling |

## Verification
A sequencer stuck in the wrong state shows on code_grp within one clock: a missing /K/ after /J/, a payload symbol where /T/ belongs, or /R/ repeated. A table mistake or a missed /H/ substitution shows on the very symbol that follows the sampled nibble. A wrong duplex term shows as a spurious crs or col bit one clock after transmit activity without receive activity. Frames of one nibble and frames restarted during /R/ are driven on purpose, because they exercise the forced transitions.

// File: rtl/txpcs_pkg.sv
package txpcs_pkg;

    localparam int NIB_W  = 4;
    localparam int CODE_W = NIB_W + 1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [NIB_W-1:0]  nib_t;

    localparam code_t SYM_IDLE = 5'b11111;
    localparam code_t SYM_J    = 5'b11000;
    localparam code_t SYM_K    = 5'b10001;
    localparam code_t SYM_T    = 5'b01101;
    localparam code_t SYM_R    = 5'b00111;
    localparam code_t SYM_H    = 5'b00100;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND_K = 2'd1,
        ST_DATA   = 2'd2,
        ST_SEND_R = 2'd3
    } tx_state_e;

endpackage

// File: rtl/txpcs_nibble_map.sv
module txpcs_nibble_map
    import txpcs_pkg::*;
(
    input  nib_t  nib,
    output code_t sym
);

    // 4B/5B data code groups (R4)
    always_comb begin
        unique case (nib)
            4'h0: sym = 5'b11110;
            4'h1: sym = 5'b01001;
            4'h2: sym = 5'b10100;
            4'h3: sym = 5'b10101;
            4'h4: sym = 5'b01010;
            4'h5: sym = 5'b01011;
            4'h6: sym = 5'b01110;
            4'h7: sym = 5'b01111;
            4'h8: sym = 5'b10010;
            4'h9: sym = 5'b10011;
            4'hA: sym = 5'b10110;
            4'hB: sym = 5'b10111;
            4'hC: sym = 5'b11010;
            4'hD: sym = 5'b11011;
            4'hE: sym = 5'b11100;
            default: sym = 5'b11101;
        endcase
    end

endmodule

// File: rtl/txpcs_framer.sv
module txpcs_framer
    import txpcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tx_en,
    input  logic  tx_er,
    input  nib_t  txd,
    input  logic  bypass,
    output code_t code_q
);

    tx_state_e state_q;
    tx_state_e state_d;
    code_t     code_d;
    code_t     data_sym;

    txpcs_nibble_map u_map (
        .nib (txd),
        .sym (data_sym)
    );

    // next state and next symbol
    always_comb begin
        state_d = state_q;
        code_d  = SYM_IDLE;
        if (bypass) begin
            state_d = ST_IDLE;                 // transition: bypass
            code_d  = {tx_er, txd};
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (tx_en) begin
                        state_d = ST_SEND_K;   // transition: start
                        code_d  = SYM_J;
                    end else begin
                        code_d  = SYM_IDLE;
                    end
                end
                ST_SEND_K: begin
                    state_d = ST_DATA;         // transition: open
                    code_d  = SYM_K;
                end
                ST_DATA: begin
                    if (tx_en) begin
                        code_d = tx_er ? SYM_H : data_sym;
                    end else begin
                        state_d = ST_SEND_R;   // transition: close
                        code_d  = SYM_T;
                    end
                end
                ST_SEND_R: begin
                    state_d = ST_IDLE;         // transition: rest
                    code_d  = SYM_R;
                end
                default: begin
                    state_d = ST_IDLE;
                    code_d  = SYM_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= SYM_IDLE;
        else        code_q <= code_d;
    end

    a_r2_idle_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !tx_en && !bypass) |=> code_q == SYM_IDLE);

    a_r3_start_j: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && tx_en && !bypass) |=> (code_q == SYM_J && state_q == ST_SEND_K));

    a_r3_then_k: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND_K && !bypass) |=> code_q == SYM_K);

    a_r5_err_sym: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && tx_en && tx_er && !bypass) |=> code_q == SYM_H);

    a_r6_close_t: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !tx_en && !bypass) |=> (code_q == SYM_T && state_q == ST_SEND_R));

    a_r6_rest_r: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND_R && !bypass) |=> (code_q == SYM_R && state_q == ST_IDLE));

    a_r7_raw_pass: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (code_q == {$past(tx_er), $past(txd)} && state_q == ST_IDLE));

endmodule

// File: rtl/txpcs_carrier.sv
module txpcs_carrier (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic rx_active,
    input  logic half_duplex,
    output logic crs,
    output logic col
);

    logic tx_counts;

    // transmit activity contributes to carrier only in half duplex
    assign tx_counts = half_duplex & tx_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crs <= 1'b0;
            col <= 1'b0;
        end else begin
            crs <= rx_active | tx_counts;
            col <= tx_counts & rx_active;
        end
    end

    a_r8_rx_raises: assert property (@(posedge clk) disable iff (!rst_n)
        rx_active |=> crs);

    a_r8_full_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_duplex && !rx_active) |=> !crs);

    a_r9_full_nocol: assert property (@(posedge clk) disable iff (!rst_n)
        !half_duplex |=> !col);

    a_r9_half_col: assert property (@(posedge clk) disable iff (!rst_n)
        (half_duplex && tx_en && rx_active) |=> col);

endmodule

// File: rtl/txpcs_encoder.sv
module txpcs_encoder
    import txpcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              tx_er,
    input  logic [NIB_W-1:0]  txd,
    input  logic              rx_active,
    input  logic              half_duplex,
    input  logic              pcs_bypass,
    input  logic              fiber_mode,
    output logic [CODE_W-1:0] code_grp,
    output logic              crs,
    output logic              col,
    output logic              scram_skip
);

    code_t code_w;

    txpcs_framer u_framer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_en  (tx_en),
        .tx_er  (tx_er),
        .txd    (txd),
        .bypass (pcs_bypass),
        .code_q (code_w)
    );

    assign code_grp = code_w;

    txpcs_carrier u_carrier (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .rx_active   (rx_active),
        .half_duplex (half_duplex),
        .crs         (crs),
        .col         (col)
    );

    // fiber links skip scrambling downstream
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scram_skip <= 1'b0;
        else        scram_skip <= fiber_mode;
    end

    a_r10_skip_on: assert property (@(posedge clk) disable iff (!rst_n)
        fiber_mode |=> scram_skip);

    a_r10_skip_off: assert property (@(posedge clk) disable iff (!rst_n)
        !fiber_mode |=> !scram_skip);

endmodule

// File: tb/txpcs_encoder_bench.sv
`timescale 1ns/1ps
module txpcs_encoder_bench;

    typedef struct packed {
        logic [9:0] stim;   // en, er, txd[3:0], rxa, hdx, byp, fib
        logic [7:0] expv;   // code[4:0], crs, col, skip
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 56;

    localparam vec_t VECS [0:NVEC-1] = '{
        '{10'b0_0_0000_0_1_0_0, 8'b11111_0_0_0, 4'd2},
        '{10'b0_1_0101_0_1_0_0, 8'b11111_0_0_0, 4'd2},
        '{10'b1_0_0101_0_1_0_0, 8'b11000_1_0_0, 4'd3},
        '{10'b1_0_0101_0_1_0_0, 8'b10001_1_0_0, 4'd3},
        '{10'b1_0_0000_0_1_0_0, 8'b11110_1_0_0, 4'd4},
        '{10'b1_0_0001_0_1_0_0, 8'b01001_1_0_0, 4'd4},
        '{10'b1_0_0111_0_1_0_0, 8'b01111_1_0_0, 4'd4},
        '{10'b1_1_1010_0_1_0_0, 8'b00100_1_0_0, 4'd5},
        '{10'b1_0_1111_1_1_0_0, 8'b11101_1_1_0, 4'd9},
        '{10'b0_0_0000_0_1_0_0, 8'b01101_0_0_0, 4'd6},
        '{10'b0_0_0000_0_1_0_0, 8'b00111_0_0_0, 4'd6},
        '{10'b0_1_0000_0_1_0_0, 8'b11111_0_0_0, 4'd2},
        '{10'b1_0_0101_0_0_0_0, 8'b11000_0_0_0, 4'd8},
        '{10'b1_0_0101_1_0_0_0, 8'b10001_1_0_0, 4'd9},
        '{10'b1_0_1001_1_0_0_0, 8'b10011_1_0_0, 4'd4},
        '{10'b1_0_1100_0_0_0_0, 8'b11010_0_0_0, 4'd8},
        '{10'b0_0_0000_0_0_0_0, 8'b01101_0_0_0, 4'd6},
        '{10'b0_0_0000_1_0_0_0, 8'b00111_1_0_0, 4'd8},
        '{10'b0_0_0000_0_0_0_0, 8'b11111_0_0_0, 4'd6},
        '{10'b0_1_0011_0_0_1_0, 8'b10011_0_0_0, 4'd7},
        '{10'b1_0_1110_0_1_1_0, 8'b01110_1_0_0, 4'd7},
        '{10'b1_1_0000_1_1_1_0, 8'b10000_1_1_0, 4'd7},
        '{10'b0_0_0000_0_0_0_0, 8'b11111_0_0_0, 4'd7},
        '{10'b0_0_0000_0_0_0_1, 8'b11111_0_0_1, 4'd10},
        '{10'b1_0_0101_0_0_0_1, 8'b11000_0_0_1, 4'd10},
        '{10'b1_0_0101_0_0_0_1, 8'b10001_0_0_1, 4'd3},
        '{10'b1_0_0010_0_0_0_1, 8'b10100_0_0_1, 4'd4},
        '{10'b0_0_0000_0_0_0_0, 8'b01101_0_0_0, 4'd10},
        '{10'b0_0_0000_0_0_0_0, 8'b00111_0_0_0, 4'd6},
        '{10'b0_0_0000_0_0_0_0, 8'b11111_0_0_0, 4'd6},
        '{10'b1_0_0101_0_0_0_0, 8'b11000_0_0_0, 4'd3},
        '{10'b1_0_0101_0_0_0_0, 8'b10001_0_0_0, 4'd3},
        '{10'b1_0_0011_0_0_0_0, 8'b10101_0_0_0, 4'd4},
        '{10'b1_0_0100_0_0_0_0, 8'b01010_0_0_0, 4'd4},
        '{10'b1_0_0110_0_0_0_0, 8'b01110_0_0_0, 4'd4},
        '{10'b1_0_1000_0_0_0_0, 8'b10010_0_0_0, 4'd4},
        '{10'b1_0_1011_0_0_0_0, 8'b10111_0_0_0, 4'd4},
        '{10'b1_0_1101_0_0_0_0, 8'b11011_0_0_0, 4'd4},
        '{10'b1_0_1110_0_0_0_0, 8'b11100_0_0_0, 4'd4},
        '{10'b0_0_0000_0_0_0_0, 8'b01101_0_0_0, 4'd6},
        '{10'b0_0_0000_0_0_0_0, 8'b00111_0_0_0, 4'd6},
        '{10'b0_0_0000_0_0_0_0, 8'b11111_0_0_0, 4'd6},
        '{10'b1_0_0101_0_0_0_0, 8'b11000_0_0_0, 4'd3},
        '{10'b0_0_0000_0_0_0_0, 8'b10001_0_0_0, 4'd3},
        '{10'b0_0_0000_0_0_0_0, 8'b01101_0_0_0, 4'd6},
        '{10'b0_0_0000_0_0_0_0, 8'b00111_0_0_0, 4'd6},
        '{10'b0_0_0000_0_0_0_0, 8'b11111_0_0_0, 4'd6},
        '{10'b1_1_0101_0_0_0_0, 8'b11000_0_0_0, 4'd3},
        '{10'b1_0_0101_0_0_0_0, 8'b10001_0_0_0, 4'd3},
        '{10'b0_0_0000_0_0_0_0, 8'b01101_0_0_0, 4'd6},
        '{10'b1_0_0101_0_0_0_0, 8'b00111_0_0_0, 4'd6},
        '{10'b1_0_0101_0_0_0_0, 8'b11000_0_0_0, 4'd3},
        '{10'b0_0_0000_0_0_0_0, 8'b10001_0_0_0, 4'd3},
        '{10'b0_0_0000_0_0_0_0, 8'b01101_0_0_0, 4'd6},
        '{10'b0_0_0000_0_0_0_0, 8'b00111_0_0_0, 4'd6},
        '{10'b0_0_0000_0_0_0_0, 8'b11111_0_0_0, 4'd6}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       rx_active = 1'b0;
    logic       half_duplex = 1'b0;
    logic       pcs_bypass = 1'b0;
    logic       fiber_mode = 1'b0;
    logic [4:0] code_grp;
    logic       crs;
    logic       col;
    logic       scram_skip;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    txpcs_encoder u_txpcs_encoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .tx_er       (tx_er),
        .txd         (txd),
        .rx_active   (rx_active),
        .half_duplex (half_duplex),
        .pcs_bypass  (pcs_bypass),
        .fiber_mode  (fiber_mode),
        .code_grp    (code_grp),
        .crs         (crs),
        .col         (col),
        .scram_skip  (scram_skip)
    );

    function automatic string tag(input logic [3:0] r);
        case (r)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic drive(input logic [9:0] s);
        {tx_en, tx_er, txd, rx_active, half_duplex, pcs_bypass, fiber_mode} = s;
    endtask

    task automatic check(input logic [7:0] e, input logic [3:0] r, input int idx);
        logic [7:0] got;
        got = {code_grp, crs, col, scram_skip};
        n_checks++;
        if (got !== e) begin
            n_fails++;
            $display("FAIL %s step %0d: got code=%b crs=%b col=%b skip=%b, expected code=%b crs=%b col=%b skip=%b",
                     tag(r), idx, got[7:3], got[2], got[1], got[0], e[7:3], e[2], e[1], e[0]);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: outputs held at reset values
        drive(10'b1_1_1010_1_1_0_1);
        #35;
        check(8'b11111_0_0_0, 4'd1, -1);
        @(negedge clk);
        drive(10'b0_0_0000_0_1_0_0);
        rst_n = 1'b1;
        @(posedge clk); #5;
        check(8'b11111_0_0_0, 4'd1, -2);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VECS[i].stim);
            @(posedge clk); #5;
            check(VECS[i].expv, VECS[i].req, i);
        end

        // R1: reset in mid-frame returns everything to rest
        @(negedge clk);
        drive(10'b1_0_0101_1_1_0_1);
        @(posedge clk); #5;
        check(8'b11000_1_1_1, 4'd3, 100);
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check(8'b11111_0_0_0, 4'd1, 101);
        @(negedge clk);
        drive(10'b0_0_0000_0_1_0_0);
        rst_n = 1'b1;
        @(posedge clk); #5;
        check(8'b11111_0_0_0, 4'd1, 102);
        // R3: a fresh frame after reset opens with J then K
        @(negedge clk);
        drive(10'b1_0_0101_0_1_0_0);
        @(posedge clk); #5;
        check(8'b11000_1_0_0, 4'd3, 103);
        @(posedge clk); #5;
        check(8'b10001_1_0_0, 4'd3, 104);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule